// File: doc/BRIEF.md
# Single-Cycle 32-bit Load-Store Integer Core

This core runs a small 32-bit integer instruction subset, and it completes one instruction in every clock cycle. Each cycle it fetches a word from an internal instruction array at the program counter. It decodes the word as one of three fixed formats: register, immediate or jump. It reads two registers from a 32 x 32-bit file and computes a result in the ALU. It then writes a register or stores to an internal data array, and picks the next program counter. The subset is add, sub, set-less-than in register and immediate forms, add-immediate, upper-immediate load, word load and store, branch-if-equal, branch-if-not-equal and an absolute jump.

Both memories are filled through a load port. The load port is honoured only while the active-low reset is held. After reset releases, the core starts at address 0. Each executed instruction shows its effect on a set of trace outputs in the same cycle: the current program counter, the register write and the memory store. An environment can follow execution from these outputs alone.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, pc_o is 0 and neither wb_en_o nor st_en_o is asserted. After release, the first instruction executed is the word at address 0.
- R2: A load-port write (ld_en high, ld_dmem selecting data array when 1 and instruction array when 0, word index on ld_addr) takes effect on a rising edge only while rst_n is low. While the core runs, the port changes neither array.
- R3: Opcode 0 with shamt 0 selects the register form. funct 32 writes rs+rt into rd, and funct 34 writes rs-rt into rd. Both wrap modulo 2^32.
- R4: slt (opcode 0, funct 42) writes 1 into rd when rs < rt as signed values, and 0 otherwise. slti (opcode 10) compares rs against the sign-extended immediate and writes 1 or 0 into rt.
- R5: addi (opcode 8) writes rs plus the sign-extended imm[15:0] into rt. lui (opcode 15) writes {imm, 16'h0000} into rt.
- R6: Register 0 reads as zero. A write to it is dropped and is not reported on wb_en_o.
- R7: lw (opcode 35) loads the word at rs+sext(imm) into rt. sw (opcode 43) stores rt at that address and shows address and data on st_addr_o/st_data_o with st_en_o high. Array words are selected by address bits [AW+1:2].
- R8: beq (opcode 4) and bne (opcode 5) compare rs with rt. When taken, the next PC is PC+4+sext(imm)*4, which may be negative. Otherwise the next PC is PC+4.
- R9: j (opcode 2) sets PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R10: An undefined opcode, an undefined funct, or a nonzero shamt in the register form writes nothing, stores nothing and advances PC by 4.
- R11: Every instruction other than a taken branch or a jump advances PC by exactly 4. PC is always word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_en | input | 1 | Load-port write strobe (only honoured in reset) |
| ld_dmem | input | 1 | 1 selects data array, 0 instruction array |
| ld_addr | input | LD_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en_o | output | 1 | A nonzero register is written at the next edge |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value written to the register |
| st_en_o | output | 1 | A word store happens at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Stored word |

## Verification
The bench targets a number of corner cases, and each one shows a different fault:
- A backward branch out of address 0 wraps the PC to the top of the address space. A core that drops the PC+4 term or the scaling by four lands on the wrong word.
- The jump taken from there keeps the high region of PC+4. Taking those bits from PC instead, or zeroing them, leaves the core stranded in the wrong region.
- The signed compares use the most negative value. An unsigned compare would invert their results.
- Writes to register 0 must read back as zero.
- Load-port strobes sent while the core runs must later load the old memory contents.
- Undefined encodings must neither write nor store.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_JMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_BNE  = 6'd5;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_LUI  = 6'd15;
  localparam logic [5:0] OPC_LW   = 6'd35;
  localparam logic [5:0] OPC_SW   = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SLT = 2'd2,
    ALU_UPR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic    reg_we;   // instruction writes a register
    logic    dst_rd;   // destination is rd (else rt)
    logic    b_imm;    // ALU operand B is the extended immediate
    alu_fn_e alu_fn;
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
  } ctrl_t;

endpackage

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int WIDTH = XLEN,
  localparam int AW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra_a,
  input  logic [AW-1:0]    ra_b,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b
);

  logic [WIDTH-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic sel;
      assign sel = we && (wa == AW'(g));
      always_ff @(posedge clk) begin
        if (sel) begin
          regs[g] <= wd;
        end
      end
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  // R3
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && ($past(wa) != '0) && (ra_a == $past(wa))) |-> (rd_a == $past(wd)));

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && ($past(wa) == '0) && (ra_b == '0)) |-> (rd_b == '0));

endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl,
  output logic [RIDX-1:0] rs,
  output logic [RIDX-1:0] rt,
  output logic [RIDX-1:0] rd,
  output logic [XLEN-1:0] imm_sx,
  output logic [25:0]     jtgt
);

  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] sh;

  assign opc    = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign sh     = instr[10:6];
  assign fn     = instr[5:0];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign jtgt   = instr[25:0];

  always_comb begin
    ctrl        = '0;
    ctrl.alu_fn = ALU_ADD;
    case (opc)
      OPC_REG: begin
        if (sh == 5'd0) begin
          ctrl.dst_rd = 1'b1;
          case (fn)
            FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_ADD; end
            FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_SUB; end
            FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_SLT; end
            default: ctrl.reg_we = 1'b0;
          endcase
        end
      end
      OPC_ADDI: begin ctrl.reg_we = 1'b1; ctrl.b_imm = 1'b1; end
      OPC_SLTI: begin ctrl.reg_we = 1'b1; ctrl.b_imm = 1'b1; ctrl.alu_fn = ALU_SLT; end
      OPC_LUI:  begin ctrl.reg_we = 1'b1; ctrl.b_imm = 1'b1; ctrl.alu_fn = ALU_UPR; end
      OPC_LW:   begin ctrl.reg_we = 1'b1; ctrl.b_imm = 1'b1; ctrl.mem_rd = 1'b1; end
      OPC_SW:   begin ctrl.b_imm = 1'b1; ctrl.mem_wr = 1'b1; end
      OPC_BEQ:  ctrl.br_eq = 1'b1;
      OPC_BNE:  ctrl.br_ne = 1'b1;
      OPC_JMP:  ctrl.jmp = 1'b1;
      default:  ctrl = '0;
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int WIDTH = XLEN
) (
  input  alu_fn_e          fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] diff;
  logic             lt;

  assign diff = a - b;
  // signed less-than from operand signs and the difference sign
  assign lt = (a[WIDTH-1] != b[WIDTH-1]) ? a[WIDTH-1] : diff[WIDTH-1];

  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(WIDTH-1){1'b0}}, lt};
      ALU_UPR: y = {b[15:0], {(WIDTH-16){1'b0}}};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import core_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  output logic [XLEN-1:0]  pc_o,
  output logic             wb_en_o,
  output logic [RIDX-1:0]  wb_idx_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             st_en_o,
  output logic [XLEN-1:0]  st_addr_o,
  output logic [XLEN-1:0]  st_data_o
);

  localparam int IWORDS = 1 << IMEM_AW;
  localparam int DWORDS = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IWORDS];
  logic [XLEN-1:0] dmem [DWORDS];

  logic [XLEN-1:0] pc_q, pc_d, pc4, br_tgt, j_tgt;
  logic [XLEN-1:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y, mem_q, wb_val;
  logic [RIDX-1:0] rs, rt, rd, dst;
  logic [25:0]     jtgt;
  ctrl_t           ctrl;
  logic            taken, redirect, rf_we, st_we;
  logic            dm_we;
  logic [DMEM_AW-1:0] dm_idx;
  logic [XLEN-1:0]    dm_wd;

  // ---------------- instruction array (load port only) ----------------
  logic im_we;
  assign im_we = !rst_n && ld_en && !ld_dmem;

  always_ff @(posedge clk) begin
    if (im_we) begin
      imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
    end
  end

  assign instr = imem[pc_q[IMEM_AW+1:2]];

  // ---------------- decode, registers, ALU ----------------
  core_decode u_dec (
    .instr  (instr),
    .ctrl   (ctrl),
    .rs     (rs),
    .rt     (rt),
    .rd     (rd),
    .imm_sx (imm_sx),
    .jtgt   (jtgt)
  );

  assign dst   = ctrl.dst_rd ? rd : rt;
  assign rf_we = rst_n && ctrl.reg_we;
  assign st_we = rst_n && ctrl.mem_wr;

  core_regfile #(.NREG(32), .WIDTH(XLEN)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (rf_we),
    .wa   (dst),
    .wd   (wb_val),
    .ra_a (rs),
    .ra_b (rt),
    .rd_a (rs_val),
    .rd_b (rt_val)
  );

  assign alu_b = ctrl.b_imm ? imm_sx : rt_val;

  core_alu #(.WIDTH(XLEN)) u_alu (
    .fn(ctrl.alu_fn),
    .a (rs_val),
    .b (alu_b),
    .y (alu_y)
  );

  // ---------------- data array ----------------
  assign mem_q  = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_val = ctrl.mem_rd ? mem_q : alu_y;

  always_comb begin
    if (!rst_n) begin
      dm_we  = ld_en && ld_dmem;
      dm_idx = ld_addr[DMEM_AW-1:0];
      dm_wd  = ld_data;
    end else begin
      dm_we  = st_we;
      dm_idx = alu_y[DMEM_AW+1:2];
      dm_wd  = rt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (dm_we) begin
      dmem[dm_idx] <= dm_wd;
    end
  end

  // ---------------- next PC ----------------
  assign pc4      = pc_q + 32'd4;
  assign br_tgt   = pc4 + {imm_sx[XLEN-3:0], 2'b00};
  assign j_tgt    = {pc4[31:28], jtgt, 2'b00};
  assign taken    = (ctrl.br_eq && (rs_val == rt_val)) ||
                    (ctrl.br_ne && (rs_val != rt_val));
  assign redirect = taken || ctrl.jmp;

  always_comb begin
    if (ctrl.jmp)  pc_d = j_tgt;
    else if (taken) pc_d = br_tgt;
    else            pc_d = pc4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // ---------------- trace outputs ----------------
  assign pc_o      = pc_q;
  assign wb_en_o   = rf_we && (dst != '0);
  assign wb_idx_o  = dst;
  assign wb_data_o = wb_val;
  assign st_en_o   = st_we;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> (pc_q == $past(pc_q) + 32'd4));

  // R11
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  // R9
  jmp_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.jmp |=> (pc_q[31:28] == $past(pc4[31:28])));

  // R7
  st_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_en_o && wb_en_o));

  // R4
  slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && ctrl.alu_fn == ALU_SLT && !ctrl.mem_rd) |-> (wb_data_o[XLEN-1:1] == '0));

  // R10
  ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.mem_rd, ctrl.mem_wr, ctrl.br_eq | ctrl.br_ne, ctrl.jmp}));

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en, ld_dmem;
  logic [AW-1:0] ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_en_o, st_en_o;
  logic [4:0]  wb_idx_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sc_core #(.IMEM_AW(AW), .DMEM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
    .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  // reference state
  logic [31:0] m_imem [NW];
  logic [31:0] m_dmem [NW];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(int idx, logic [5:0] op, logic [5:0] fn);
    if (idx == 31) return "R2";
    if (idx == 25 || idx == 26) return "R6";
    if (idx == 39 || idx == 40) return "R10";
    case (op)
      6'd0:  return (fn == 6'd42) ? "R4" : "R3";
      6'd8:  return "R5";
      6'd15: return "R5";
      6'd10: return "R4";
      6'd35: return "R7";
      6'd43: return "R7";
      6'd4:  return "R8";
      6'd5:  return "R8";
      6'd2:  return "R9";
      default: return "R10";
    endcase
  endfunction

  // compare DUT trace against the model for the current cycle, then advance the model
  task automatic step_model();
    logic [31:0] ins, a, b, sx, res, nxt, addr;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    logic        e_wb, e_st;
    logic [4:0]  e_idx;
    string       t;
    int          idx;
    idx = int'(m_pc[AW+1:2]);
    ins = m_imem[idx];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    sh = ins[10:6];  fn = ins[5:0];
    a = m_reg[rs]; b = m_reg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    nxt = m_pc + 32'd4;
    e_wb = 1'b0; e_st = 1'b0; e_idx = rt; res = '0; addr = a + sx;
    case (op)
      6'd0: if (sh == 0) begin
        e_idx = rd;
        if (fn == 6'd32) begin e_wb = 1; res = a + b; end
        else if (fn == 6'd34) begin e_wb = 1; res = a - b; end
        else if (fn == 6'd42) begin e_wb = 1; res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; end
      end
      6'd8:  begin e_wb = 1; res = a + sx; end
      6'd10: begin e_wb = 1; res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; end
      6'd15: begin e_wb = 1; res = {ins[15:0], 16'h0}; end
      6'd35: begin e_wb = 1; res = m_dmem[addr[AW+1:2]]; end
      6'd43: e_st = 1;
      6'd4:  if (a == b) nxt = m_pc + 32'd4 + (sx << 2);
      6'd5:  if (a != b) nxt = m_pc + 32'd4 + (sx << 2);
      6'd2:  nxt = {m_pc[31:28] + ((m_pc[27:0] == 28'hFFFFFFC) ? 4'd1 : 4'd0), ins[25:0], 2'b00};
      default: ;
    endcase
    if (op == 6'd2) begin
      logic [31:0] p4;
      p4 = m_pc + 32'd4;
      nxt = {p4[31:28], ins[25:0], 2'b00};
    end
    if (e_idx == 5'd0) e_wb = 1'b0;
    t = tag_of(idx, op, fn);
    chk(pc_o == m_pc, (op == 6'd4 || op == 6'd5 || op == 6'd2) ? t : "R11", "pc", pc_o, m_pc);
    chk(wb_en_o == e_wb, t, "wb_en", 32'(wb_en_o), 32'(e_wb));
    if (e_wb) begin
      chk(wb_idx_o == e_idx, t, "wb_idx", 32'(wb_idx_o), 32'(e_idx));
      chk(wb_data_o == res, t, "wb_data", wb_data_o, res);
    end
    chk(st_en_o == e_st, t, "st_en", 32'(st_en_o), 32'(e_st));
    if (e_st) begin
      chk(st_addr_o == addr, t, "st_addr", st_addr_o, addr);
      chk(st_data_o == b, t, "st_data", st_data_o, b);
    end
    // advance
    if (e_wb) m_reg[e_idx] = res;
    if (e_st) m_dmem[addr[AW+1:2]] = b;
    m_pc = nxt;
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 0; ld_dmem = 0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < NW; i++) begin
      m_imem[i] = {6'd63, 26'd0};
      m_dmem[i] = 32'h1000_0000 + 32'(i * 3);
    end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;

    m_imem[0]  = enc_i(4, 0, 0, -3);        // beq r0,r0 -> wraps to 0xFFFFFFF8
    m_imem[62] = enc_j(16);                 // j: keeps region F
    m_imem[16] = enc_i(15, 0, 1, 16'h8000); // lui r1
    m_imem[17] = enc_i(8, 0, 2, -1);        // addi r2 = -1
    m_imem[18] = enc_i(8, 0, 3, 5);         // addi r3 = 5
    m_imem[19] = enc_r(1, 2, 4, 32);        // add wraps
    m_imem[20] = enc_r(3, 2, 5, 34);        // sub
    m_imem[21] = enc_r(1, 3, 6, 42);        // slt min < 5
    m_imem[22] = enc_r(3, 1, 7, 42);        // slt 5 < min
    m_imem[23] = enc_i(10, 2, 8, 0);        // slti -1 < 0
    m_imem[24] = enc_i(10, 3, 9, 5);        // slti 5 < 5
    m_imem[25] = enc_i(8, 3, 0, 7);         // write to r0
    m_imem[26] = enc_r(0, 3, 10, 32);       // read r0
    m_imem[27] = enc_i(8, 0, 11, 16);
    m_imem[28] = enc_i(43, 11, 4, -4);      // sw r4 -> 12
    m_imem[29] = enc_i(35, 11, 12, -4);     // lw back
    m_imem[30] = enc_i(35, 0, 13, 40);      // preloaded word
    m_imem[31] = enc_i(35, 0, 14, 20);      // word targeted by ignored load
    m_imem[32] = enc_i(4, 3, 10, 2);        // beq taken
    m_imem[33] = enc_i(8, 0, 15, 1);
    m_imem[34] = enc_i(8, 0, 15, 2);
    m_imem[35] = enc_i(5, 3, 10, 1);        // bne not taken
    m_imem[36] = enc_i(8, 0, 16, 3);
    m_imem[37] = enc_i(8, 16, 16, -1);
    m_imem[38] = enc_i(5, 16, 0, -2);       // loop back
    m_imem[39] = {6'd63, 26'h3ff_ffff};     // undefined opcode
    m_imem[40] = {6'd0, 5'd3, 5'd3, 5'd17, 5'd0, 6'd63}; // undefined funct
    m_imem[41] = enc_j(41);                 // self loop

    // preload through the load port while held in reset
    for (int i = 0; i < 2 * NW; i++) begin
      @(negedge clk);
      ld_en = 1; ld_dmem = (i >= NW); ld_addr = AW'(i % NW);
      ld_data = (i >= NW) ? m_dmem[i % NW] : m_imem[i];
    end
    @(negedge clk);
    ld_en = 0;
    #1;
    // R1: reset state
    chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
    chk(!wb_en_o && !st_en_o, "R1", "no effects in reset", 32'({wb_en_o, st_en_o}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 70; c++) begin
      #1;
      step_model();
      // R2: strobes while running must be ignored
      ld_en = (c == 3 || c == 4);
      ld_dmem = (c == 3);
      ld_addr = (c == 3) ? AW'(5) : AW'(37);
      ld_data = 32'hDEAD_BEEF;
      @(negedge clk);
    end
    ld_en = 0;
    chk(pc_o == 32'hF000_00A4, "R9", "final self-loop pc", pc_o, 32'hF000_00A4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule